// File: doc/BRIEF.md
# Device Control Register Block with Split-Phase Reset

This block is the register front end of a paravirtual-style device. A driver reaches it over a simple 32-bit read/write bus. Through it the driver reads an identification word and a version word, and it writes progress flags into a driver status register. It also sees latched interrupt events and clears them with an acknowledge mask. Queues are reached through a queue select register, which steers accesses to a per-queue ready bit and a per-queue reset register.

When the driver writes zero to the status register, the device resets. This reset can take many cycles. A small sequencer asks the back-end logic to drain and waits for it to report that it is done. The sequencer then clears the interrupt and queue-ready state, and only then sets status to zero. The `VERSION` parameter decides what the bus sees while this happens. With version 2 the bus write is held off until the reset is over. With version 3 the write finishes at once and the driver polls status until it reads zero. A reset requested while status is already zero is always finished before the write completes.

The bus handshake works like this. A request is held with `bus_valid` until a cycle in which `bus_ready` is high. That cycle completes the transfer, and `bus_rdata` is valid in it.

Top module: `devctl_regs`

## Requirements
- R1: A read at offset 0x000 returns 0x74726976. A read at offset 0x004 returns the `VERSION` parameter, which is 2 or 3.
- R2: A status write (offset 0x070) whose low 8 bits are not all zero stores those 8 bits, and a later read of 0x070 returns them zero-extended.
- R3: With version 3 and a non-zero status, a status write whose low 8 bits are zero completes in the cycle it is presented. Status keeps its old value while `drain_req` is high, and becomes zero only as the last step of the reset.
- R4: With version 2, a zero status write holds `bus_ready` low until the reset has finished. The first read that follows returns status zero.
- R5: With version 3 and status already zero, a zero status write stalls until the whole reset, including the drain handshake, has finished.
- R6: A reset raises `drain_req` and holds it until `drain_done`. It then clears every interrupt status bit and the ready bit of every queue before status reads zero.
- R7: Interrupt status (offset 0x060, bit i for event input i) sets when `irq_event[i]` is high. It stays set until a write to offset 0x064 with bit i set. Bits that have no event read zero, and 0x064 itself reads zero.
- R8: Offset 0x030 holds the queue select. Offset 0x044 bit 0 reads and writes the ready bit of the selected queue. If the select is not below `NUM_Q`, 0x044 reads zero and writes to it are ignored.
- R9: Writing a word with bit 0 set to offset 0x0C0 starts a reset of the selected queue and raises `qrst_req` for that queue. Offset 0x0C0 bit 0 reads 1 until `qrst_done` for that queue, and reads 0 after it.
- R10: Status writes, zero or not, that are accepted while a background reset is in progress leave status unchanged.
- R11: After the reset input, status, interrupt status and all queue ready bits read zero. Reads of unmapped offsets return zero.
- R12: Every access that does not start a synchronous reset completes in the first cycle it is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_valid | input | 1 | Request present; held until accepted |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_ready | output | 1 | Transfer completes in this cycle |
| bus_rdata | output | 32 | Read data, valid while bus_ready is high |
| drain_req | output | 1 | Asks the back-end to drain during a device reset |
| drain_done | input | 1 | Back-end has drained |
| irq_event | input | NUM_IRQ | Interrupt event pulses |
| qrst_req | output | NUM_Q | Queue reset pending, one bit per queue |
| qrst_done | input | NUM_Q | Queue reset finished, one bit per queue |

## Verification
The reset path is exercised with three starting conditions: a non-zero status under version 3, a zero status under version 3, and any status under version 2. These show apart the immediate completion, the stalled completion, and the choice of the stalled path by version or by status. The background case is probed while the drain is still pending. One read there shows that status keeps its old value, and a write there shows that status writes are ignored. Polling then shows that interrupt and queue state are cleared before status drops. Register accesses come from a table that covers both in-range and out-of-range queue selects, so steered reads are separated from ignored writes. Interrupt tests acknowledge one bit at a time with partial masks, which shows that each bit is held and cleared independently.

// File: rtl/devctl_pkg.sv
`timescale 1ns/1ps
package devctl_pkg;
    localparam int          ADDR_W   = 12;
    localparam logic [31:0] ID_WORD  = 32'h7472_6976;

    localparam logic [ADDR_W-1:0] OFS_ID   = 12'h000;
    localparam logic [ADDR_W-1:0] OFS_VER  = 12'h004;
    localparam logic [ADDR_W-1:0] OFS_QSEL = 12'h030;
    localparam logic [ADDR_W-1:0] OFS_QRDY = 12'h044;
    localparam logic [ADDR_W-1:0] OFS_ISR  = 12'h060;
    localparam logic [ADDR_W-1:0] OFS_IACK = 12'h064;
    localparam logic [ADDR_W-1:0] OFS_STAT = 12'h070;
    localparam logic [ADDR_W-1:0] OFS_QRST = 12'h0C0;

    typedef enum logic [1:0] {
        RS_IDLE,
        RS_DRAIN,
        RS_CLEAR,
        RS_DONE
    } rst_state_e;

    // A zero write must finish before the bus returns for version 2,
    // and for any version when status is already zero.
    function automatic logic needs_sync(input int ver, input logic stat_is_zero);
        return (ver == 2) || stat_is_zero;
    endfunction
endpackage

// File: rtl/devctl_rst_seq.sv
`timescale 1ns/1ps
module devctl_rst_seq
    import devctl_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  logic       drain_done,
    output rst_state_e state,
    output logic       drain_req,
    output logic       clr_all,
    output logic       finish
);
    rst_state_e state_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= RS_IDLE;
        end else begin
            unique case (state_q)
                RS_IDLE:  if (start) state_q <= RS_DRAIN;
                RS_DRAIN: if (drain_done) state_q <= RS_CLEAR;
                RS_CLEAR: state_q <= RS_DONE;
                RS_DONE:  state_q <= RS_IDLE;
                default:  state_q <= RS_IDLE;
            endcase
        end
    end

    assign state     = state_q;
    assign drain_req = (state_q == RS_DRAIN);
    assign clr_all   = (state_q == RS_CLEAR);
    assign finish    = (state_q == RS_DONE);

    // R6
    drain_wait_chk: assert property (@(posedge clk) disable iff (rst)
        (drain_req && !drain_done) |=> drain_req);
    // R6
    clear_before_done_chk: assert property (@(posedge clk) disable iff (rst)
        clr_all |=> finish);
endmodule

// File: rtl/devctl_irq.sv
`timescale 1ns/1ps
module devctl_irq #(
    parameter int NUM_IRQ = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_IRQ-1:0] event_in,
    input  logic               ack_we,
    input  logic [NUM_IRQ-1:0] ack_mask,
    input  logic               clr_all,
    output logic [NUM_IRQ-1:0] pend
);
    logic [NUM_IRQ-1:0] pend_q;
    logic [NUM_IRQ-1:0] pend_n;

    always_comb begin
        pend_n = (pend_q & ~(ack_we ? ack_mask : '0)) | event_in;
        if (clr_all) pend_n = '0;
    end

    always_ff @(posedge clk) begin
        if (rst) pend_q <= '0;
        else     pend_q <= pend_n;
    end

    assign pend = pend_q;

    // R7
    irq_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !clr_all |=> ((pend_q & $past(pend_q & ~(ack_we ? ack_mask : '0)))
                      == $past(pend_q & ~(ack_we ? ack_mask : '0))));
    // R6
    irq_clear_chk: assert property (@(posedge clk) disable iff (rst)
        clr_all |=> (pend_q == '0));
endmodule

// File: rtl/devctl_queues.sv
`timescale 1ns/1ps
module devctl_queues #(
    parameter int NUM_Q  = 4,
    parameter int QSEL_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [QSEL_W-1:0] sel,
    input  logic              rdy_we,
    input  logic              rdy_wbit,
    input  logic              qrst_we,
    input  logic              clr_all,
    input  logic [NUM_Q-1:0]  qrst_done,
    output logic [NUM_Q-1:0]  qrst_pend,
    output logic              rdy_rd,
    output logic              qrst_rd
);
    localparam int IDX_W = (NUM_Q > 1) ? $clog2(NUM_Q) : 1;

    logic [NUM_Q-1:0] rdy_q;
    logic [NUM_Q-1:0] pend_q;
    logic             sel_ok;
    logic [IDX_W-1:0] idx;

    assign sel_ok = (sel < QSEL_W'(NUM_Q));
    assign idx    = sel[IDX_W-1:0];

    for (genvar i = 0; i < NUM_Q; i++) begin : g_queue
        logic hit;
        assign hit = sel_ok && (sel == QSEL_W'(i));

        always_ff @(posedge clk) begin
            if (rst) begin
                rdy_q[i]  <= 1'b0;
                pend_q[i] <= 1'b0;
            end else begin
                if (clr_all)           rdy_q[i] <= 1'b0;
                else if (rdy_we && hit) rdy_q[i] <= rdy_wbit;

                if (qrst_we && hit)     pend_q[i] <= 1'b1;
                else if (qrst_done[i]) pend_q[i] <= 1'b0;
            end
        end
    end

    assign qrst_pend = pend_q;
    assign rdy_rd    = sel_ok ? rdy_q[idx]  : 1'b0;
    assign qrst_rd   = sel_ok ? pend_q[idx] : 1'b0;

    // R6
    qrdy_clear_chk: assert property (@(posedge clk) disable iff (rst)
        clr_all |=> (rdy_q == '0));
    // R8
    qsel_range_chk: assert property (@(posedge clk) disable iff (rst)
        (rdy_we && !sel_ok && !clr_all) |=> $stable(rdy_q));
    // R9
    qrst_hold_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((pend_q & $past(pend_q & ~qrst_done)) == $past(pend_q & ~qrst_done)));
endmodule

// File: rtl/devctl_regs.sv
`timescale 1ns/1ps
module devctl_regs
    import devctl_pkg::*;
#(
    parameter int VERSION = 3,
    parameter int NUM_Q   = 4,
    parameter int NUM_IRQ = 2,
    parameter int STAT_W  = 8,
    parameter int QSEL_W  = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               bus_valid,
    input  logic               bus_write,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [31:0]        bus_wdata,
    output logic               bus_ready,
    output logic [31:0]        bus_rdata,
    output logic               drain_req,
    input  logic               drain_done,
    input  logic [NUM_IRQ-1:0] irq_event,
    output logic [NUM_Q-1:0]   qrst_req,
    input  logic [NUM_Q-1:0]   qrst_done
);
    localparam logic [31:0] VER_WORD = 32'(VERSION);

    logic [STAT_W-1:0] status_q;
    logic [QSEL_W-1:0] qsel_q;
    logic              stall_own_q;

    rst_state_e rs_state;
    logic rs_idle, rs_start, rs_clr, rs_finish;
    logic stat_hit, wzero, launch_sync, launch_async;
    logic accept, wr_acc;
    logic [NUM_IRQ-1:0] irq_pend;
    logic q_rdy_rd, q_rst_rd;
    logic unused_wdata_hi;

    assign unused_wdata_hi = ^bus_wdata[31:STAT_W];

    assign rs_idle      = (rs_state == RS_IDLE);
    assign stat_hit     = bus_valid && bus_write && (bus_addr == OFS_STAT);
    assign wzero        = (bus_wdata[STAT_W-1:0] == '0);
    assign launch_sync  = stat_hit && wzero && rs_idle &&
                          needs_sync(VERSION, status_q == '0);
    assign launch_async = stat_hit && wzero && rs_idle &&
                          !needs_sync(VERSION, status_q == '0);
    assign rs_start     = launch_sync || launch_async;

    always_comb begin
        if (!bus_valid)       bus_ready = 1'b0;
        else if (launch_sync) bus_ready = 1'b0;
        else if (stall_own_q) bus_ready = rs_finish;
        else                  bus_ready = 1'b1;
    end

    assign accept = bus_valid && bus_ready;
    assign wr_acc = accept && bus_write;

    devctl_rst_seq u_seq (
        .clk       (clk),
        .rst       (rst),
        .start     (rs_start),
        .drain_done(drain_done),
        .state     (rs_state),
        .drain_req (drain_req),
        .clr_all   (rs_clr),
        .finish    (rs_finish)
    );

    devctl_irq #(.NUM_IRQ(NUM_IRQ)) u_irq (
        .clk     (clk),
        .rst     (rst),
        .event_in(irq_event),
        .ack_we  (wr_acc && (bus_addr == OFS_IACK)),
        .ack_mask(bus_wdata[NUM_IRQ-1:0]),
        .clr_all (rs_clr),
        .pend    (irq_pend)
    );

    devctl_queues #(.NUM_Q(NUM_Q), .QSEL_W(QSEL_W)) u_queues (
        .clk      (clk),
        .rst      (rst),
        .sel      (qsel_q),
        .rdy_we   (wr_acc && (bus_addr == OFS_QRDY)),
        .rdy_wbit (bus_wdata[0]),
        .qrst_we  (wr_acc && (bus_addr == OFS_QRST) && bus_wdata[0]),
        .clr_all  (rs_clr),
        .qrst_done(qrst_done),
        .qrst_pend(qrst_req),
        .rdy_rd   (q_rdy_rd),
        .qrst_rd  (q_rst_rd)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            status_q    <= '0;
            qsel_q      <= '0;
            stall_own_q <= 1'b0;
        end else begin
            if (launch_sync)    stall_own_q <= 1'b1;
            else if (rs_finish) stall_own_q <= 1'b0;

            if (rs_finish)
                status_q <= '0;
            else if (wr_acc && (bus_addr == OFS_STAT) && rs_idle && !wzero)
                status_q <= bus_wdata[STAT_W-1:0];

            if (wr_acc && (bus_addr == OFS_QSEL))
                qsel_q <= bus_wdata[QSEL_W-1:0];
        end
    end

    always_comb begin
        unique case (bus_addr)
            OFS_ID:   bus_rdata = ID_WORD;
            OFS_VER:  bus_rdata = VER_WORD;
            OFS_QSEL: bus_rdata = 32'(qsel_q);
            OFS_QRDY: bus_rdata = {31'b0, q_rdy_rd};
            OFS_ISR:  bus_rdata = 32'(irq_pend);
            OFS_STAT: bus_rdata = 32'(status_q);
            OFS_QRST: bus_rdata = {31'b0, q_rst_rd};
            default:  bus_rdata = 32'h0;
        endcase
    end

    // R3
    status_hold_chk: assert property (@(posedge clk) disable iff (rst)
        ((status_q != '0) && !rs_finish) |=> (status_q != '0));
    // R10
    busy_ignore_chk: assert property (@(posedge clk) disable iff (rst)
        (!rs_idle && !rs_finish) |=> $stable(status_q));
    // R4 R5
    sync_done_chk: assert property (@(posedge clk) disable iff (rst)
        (stall_own_q && accept) |=> (status_q == '0));
    // R12
    no_stall_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_valid && !stall_own_q && !launch_sync) |-> bus_ready);
endmodule

// File: tb/devctl_regs_bench.sv
`timescale 1ns/1ps
module devctl_regs_bench;
    localparam int NQ = 4;
    localparam int NI = 2;

    typedef struct packed {
        logic        wr;
        logic [11:0] a;
        logic [31:0] d;
        logic [31:0] e;
        logic [3:0]  rq;
    } vec_t;

    // Register table: R1 id/version, R2 status flags, R8 queue select,
    // R7 ack offset reads zero, R11 reset values and unmapped reads.
    localparam vec_t VECS [20] = '{
        '{1'b0, 12'h000, 32'h0,  32'h7472_6976, 4'd1},
        '{1'b0, 12'h004, 32'h0,  32'h3,         4'd1},
        '{1'b0, 12'h070, 32'h0,  32'h0,         4'd11},
        '{1'b0, 12'h060, 32'h0,  32'h0,         4'd11},
        '{1'b1, 12'h070, 32'h1,  32'h0,         4'd2},
        '{1'b0, 12'h070, 32'h0,  32'h1,         4'd2},
        '{1'b1, 12'h070, 32'hF,  32'h0,         4'd2},
        '{1'b0, 12'h070, 32'h0,  32'hF,         4'd2},
        '{1'b1, 12'h030, 32'h1,  32'h0,         4'd8},
        '{1'b1, 12'h044, 32'h1,  32'h0,         4'd8},
        '{1'b0, 12'h044, 32'h0,  32'h1,         4'd8},
        '{1'b1, 12'h030, 32'h2,  32'h0,         4'd8},
        '{1'b0, 12'h044, 32'h0,  32'h0,         4'd8},
        '{1'b0, 12'h030, 32'h0,  32'h2,         4'd8},
        '{1'b1, 12'h030, 32'h9,  32'h0,         4'd8},
        '{1'b1, 12'h044, 32'h1,  32'h0,         4'd8},
        '{1'b0, 12'h044, 32'h0,  32'h0,         4'd8},
        '{1'b0, 12'h0FC, 32'h0,  32'h0,         4'd11},
        '{1'b0, 12'h064, 32'h0,  32'h0,         4'd7},
        '{1'b1, 12'h030, 32'h1,  32'h0,         4'd8}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #5 clk = ~clk;

    logic        bvalid = 1'b0;
    logic        bwrite = 1'b0;
    logic [11:0] baddr  = '0;
    logic [31:0] bwdata = '0;
    int          tgt    = 0;

    logic        rdy3, rdy2;
    logic [31:0] rd3, rd2;
    logic        dreq3, dreq2;
    logic        ddone3 = 1'b0;
    logic        ddone2 = 1'b0;
    logic [NI-1:0] ev = '0;
    logic [NQ-1:0] qreq3, qreq2;
    logic [NQ-1:0] qdone3 = '0;
    logic [NQ-1:0] qdone2;
    assign qdone2 = '0;

    devctl_regs u_devctl_regs (
        .clk(clk), .rst(rst),
        .bus_valid(bvalid && (tgt == 0)), .bus_write(bwrite),
        .bus_addr(baddr), .bus_wdata(bwdata),
        .bus_ready(rdy3), .bus_rdata(rd3),
        .drain_req(dreq3), .drain_done(ddone3),
        .irq_event(ev), .qrst_req(qreq3), .qrst_done(qdone3)
    );

    devctl_regs #(.VERSION(2)) u_devctl_regs_v2 (
        .clk(clk), .rst(rst),
        .bus_valid(bvalid && (tgt == 1)), .bus_write(bwrite),
        .bus_addr(baddr), .bus_wdata(bwdata),
        .bus_ready(rdy2), .bus_rdata(rd2),
        .drain_req(dreq2), .drain_done(ddone2),
        .irq_event('0), .qrst_req(qreq2), .qrst_done(qdone2)
    );

    int nchk = 0;
    int nerr = 0;
    int dlat = 10;
    int dcnt3 = 0;
    int dcnt2 = 0;
    int dcyc3 = 0;
    int dcyc2 = 0;
    int qcnt [NQ];

    // back-end stubs: drain done after dlat cycles, queue reset after 3
    always @(negedge clk) begin
        if (dreq3) begin dcnt3 = dcnt3 + 1; ddone3 = (dcnt3 >= dlat); end
        else begin dcnt3 = 0; ddone3 = 1'b0; end
        if (dreq2) begin dcnt2 = dcnt2 + 1; ddone2 = (dcnt2 >= dlat); end
        else begin dcnt2 = 0; ddone2 = 1'b0; end
        for (int q = 0; q < NQ; q++) begin
            if (qreq3[q]) begin qcnt[q] = qcnt[q] + 1; qdone3[q] = (qcnt[q] == 3); end
            else begin qcnt[q] = 0; qdone3[q] = 1'b0; end
        end
    end

    always @(posedge clk) begin
        if (dreq3) dcyc3 <= dcyc3 + 1;
        if (dreq2) dcyc2 <= dcyc2 + 1;
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic xfer(input int t, input bit w, input logic [11:0] a,
                        input logic [31:0] d, output logic [31:0] r, output int cyc);
        @(negedge clk);
        tgt = t; bvalid = 1'b1; bwrite = w; baddr = a; bwdata = d;
        cyc = 0; r = '0;
        while (1) begin
            #1;
            cyc++;
            if ((t == 0) ? rdy3 : rdy2) begin
                r = (t == 0) ? rd3 : rd2;
                break;
            end
            if (cyc > 5000) break;
            @(negedge clk);
        end
        @(posedge clk);
        #1 bvalid = 1'b0;
    endtask

    task automatic pulse_ev(input logic [NI-1:0] v);
        @(negedge clk); ev = v;
        @(negedge clk); ev = '0;
    endtask

    initial begin
        #1ms;
        nerr++;
        $display("FAIL watchdog: actual running expected finished");
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end

    initial begin
        logic [31:0] r;
        int c, d0, polls;
        for (int q = 0; q < NQ; q++) qcnt[q] = 0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;

        // table walk
        for (int i = 0; i < $size(VECS); i++) begin
            xfer(0, VECS[i].wr, VECS[i].a, VECS[i].d, r, c);
            chk($sformatf("R12 vec%0d single-cycle", i), 32'(c), 32'd1);
            if (!VECS[i].wr)
                chk($sformatf("R%0d vec%0d read %h", VECS[i].rq, i, VECS[i].a), r, VECS[i].e);
        end
        xfer(1, 1'b0, 12'h004, 0, r, c);
        chk("R1 version word v2", r, 32'h2);

        // interrupts
        pulse_ev(2'b01);
        xfer(0, 1'b0, 12'h060, 0, r, c); chk("R7 event0 latched", r, 32'h1);
        pulse_ev(2'b10);
        xfer(0, 1'b0, 12'h060, 0, r, c); chk("R7 both latched", r, 32'h3);
        xfer(0, 1'b1, 12'h064, 32'h1, r, c);
        xfer(0, 1'b0, 12'h060, 0, r, c); chk("R7 ack bit0 only", r, 32'h2);
        xfer(0, 1'b1, 12'h064, 32'h0, r, c);
        xfer(0, 1'b0, 12'h060, 0, r, c); chk("R7 empty mask keeps", r, 32'h2);

        // queue reset on queue 1
        xfer(0, 1'b1, 12'h0C0, 32'h1, r, c);
        #2 chk("R9 qrst_req raised", 32'(qreq3), 32'h2);
        xfer(0, 1'b0, 12'h0C0, 0, r, c); chk("R9 pending reads 1", r, 32'h1);
        repeat (6) @(posedge clk);
        xfer(0, 1'b0, 12'h0C0, 0, r, c); chk("R9 done reads 0", r, 32'h0);
        xfer(0, 1'b0, 12'h044, 0, r, c); chk("R8 q1 ready before reset", r, 32'h1);

        // background reset, version 3, status 0xF
        dlat = 10;
        d0 = dcyc3;
        xfer(0, 1'b1, 12'h070, 32'h0, r, c);
        chk("R3 async zero write single-cycle", 32'(c), 32'd1);
        xfer(0, 1'b0, 12'h070, 0, r, c);
        chk("R3 status held during drain", r, 32'hF);
        chk("R6 drain_req high", {31'b0, dreq3}, 32'h1);
        xfer(0, 1'b1, 12'h070, 32'h55, r, c);
        xfer(0, 1'b1, 12'h070, 32'h0, r, c);
        chk("R10 busy writes single-cycle", 32'(c), 32'd1);
        xfer(0, 1'b0, 12'h070, 0, r, c);
        chk("R10 status write ignored when busy", r, 32'hF);
        polls = 0;
        do begin
            xfer(0, 1'b0, 12'h070, 0, r, c);
            polls++;
        end while (r != 0 && polls < 40);
        chk("R3 status reaches zero", r, 32'h0);
        chk("R6 drain cycles", 32'(dcyc3 - d0), 32'(dlat));
        xfer(0, 1'b0, 12'h060, 0, r, c); chk("R6 irq cleared", r, 32'h0);
        xfer(0, 1'b0, 12'h044, 0, r, c); chk("R6 queue ready cleared", r, 32'h0);
        xfer(0, 1'b0, 12'h070, 0, r, c); chk("R10 late write not kept", r, 32'h0);

        // version 3, status already zero: synchronous
        dlat = 4;
        d0 = dcyc3;
        xfer(0, 1'b1, 12'h070, 32'h0, r, c);
        chk("R5 zero-status write stalls", 32'(c), 32'(dlat + 3));
        chk("R5 drain done before return", 32'(dcyc3 - d0), 32'(dlat));
        xfer(0, 1'b0, 12'h070, 0, r, c); chk("R5 status zero", r, 32'h0);

        // version 2: stalls even with non-zero status
        xfer(1, 1'b1, 12'h070, 32'h7, r, c);
        xfer(1, 1'b0, 12'h070, 0, r, c); chk("R2 v2 status store", r, 32'h7);
        d0 = dcyc2;
        xfer(1, 1'b1, 12'h070, 32'h0, r, c);
        chk("R4 v2 write stalls", 32'(c), 32'(dlat + 3));
        chk("R4 v2 drain done before return", 32'(dcyc2 - d0), 32'(dlat));
        xfer(1, 1'b0, 12'h070, 0, r, c); chk("R4 v2 status zero", r, 32'h0);

        // reset input mid-run
        xfer(0, 1'b1, 12'h070, 32'h3, r, c);
        xfer(0, 1'b1, 12'h044, 32'h1, r, c);
        pulse_ev(2'b11);
        @(negedge clk) rst = 1'b1;
        @(negedge clk) rst = 1'b0;
        xfer(0, 1'b0, 12'h070, 0, r, c); chk("R11 status after reset", r, 32'h0);
        xfer(0, 1'b0, 12'h060, 0, r, c); chk("R11 irq after reset", r, 32'h0);
        xfer(0, 1'b1, 12'h030, 32'h1, r, c);
        xfer(0, 1'b0, 12'h044, 0, r, c); chk("R11 ready after reset", r, 32'h0);

        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end
endmodule